// File: doc/BRIEF.md
# Global memory segment coalescer

This block takes one warp-wide global or local memory instruction and reduces it to the smallest set of aligned memory transactions. A request carries a lane-active mask, one address per lane, the element size in bytes and an atomic flag. The warp is split into a lower and an upper half. Within a half, active lanes whose addresses fall into the same aligned segment share one transaction. Lanes in different halves never share one.

The segment size follows the element size. For each segment the block records which of its four quarters were touched. It then narrows the transaction from 128 to 64 to 32 bytes whenever only one side of it is used, and moves the base address onto the side that is used. Atomic instructions skip merging, so every active lane gets its own transaction.

Transactions leave one at a time on a valid/ready stream. Each one carries an address, a size in bytes and the mask of the lanes it serves. A one-cycle done pulse follows the last transaction. The next request is accepted only after that pulse.

Top module: `seg_coalescer`

## Requirements
- R1: The segment is 32 bytes for a `size_i` of 1, 64 bytes for 2, and 128 bytes for 4, 8 or 16. The segment base is the lane address with the low log2(segment) bits cleared. Every `tx_addr_o` is aligned to its `tx_size_o`, and `tx_size_o` is the byte count 32, 64 or 128.
- R2: Active lanes of one half whose segment bases match are merged into one transaction. `tx_lanes_o` holds exactly those lanes: bit i is lane i, lanes 0..LANES/2-1 form half 0 and the rest form half 1. No transaction holds lanes of both halves.
- R3: With `atomic_i` high, every active lane produces a transaction of its own, with a single bit set in `tx_lanes_o`.
- R4: The quarter of a lane is (address >> (log2(segment)-2)) & 3. For a 128-byte segment, low = quarter 0 or 1 used and high = quarter 2 or 3 used. If exactly one of them is set, the size becomes 64, and 64 is added to the address when it is high.
- R5: After a 128-to-64 step, low is re-formed as quarter 0 or 2 used and high as quarter 1 or 3 used. If exactly one is set, the size becomes 32, and 32 is added when it is high.
- R6: A segment that starts at 64 bytes narrows to 32 with low = quarter 0 or 1 and high = quarter 2 or 3, adding 32 when it is high. A 32-byte segment is never narrowed.
- R7: Inactive lanes have no effect on any transaction. A request with no active lanes produces no transaction, and `done_o` is high in the cycle right after the start cycle.
- R8: Transactions appear in order of the lowest lane index they serve, so all of half 0 comes before half 1.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, the address, size and lanes hold steady. `done_o` pulses for exactly one cycle, in the cycle after the last accepted transaction, and never while `tx_valid_o` is high.
- R10: A `size_i` other than 1, 2, 4, 8 or 16 produces no transaction. Its done pulse comes with `size_err_o` high. `size_err_o` is never high without `done_o`.
- R11: A `start_i` pulse while a request is still being processed is ignored. The current transaction stream is unchanged, and no extra transaction or done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accept a new request (when idle) |
| mask_i | input | LANES | Lane-active mask |
| addr_i | input | LANES*32 | Per-lane byte addresses, lane i at bits [32i+31:32i] |
| size_i | input | 5 | Element size in bytes |
| atomic_i | input | 1 | Atomic instruction, disables merging |
| tx_valid_o | output | 1 | Transaction available |
| tx_ready_i | input | 1 | Consumer takes the transaction |
| tx_addr_o | output | 32 | Transaction base address |
| tx_size_o | output | 8 | Transaction size in bytes (32, 64, 128) |
| tx_lanes_o | output | LANES | Lanes served by the transaction |
| done_o | output | 1 | One-cycle pulse after the last transaction |
| size_err_o | output | 1 | Illegal element size, valid with done_o |

## Verification
A wrong pending-lane mask shows up at the ports within one handshake. Either a lane appears in two transactions, or a lane never appears and the done pulse comes early. The bench catches both by comparing the full transaction list and the done cycle against its own model. A faulty quarter record or narrowing step changes `tx_addr_o` or `tx_size_o` on the very transaction it affects. A merge that crosses halves or an unwanted atomic merge changes both the transaction count and the lane masks. Stalls are exercised with a gapped ready pattern, so a change in the held outputs is seen on the next cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 5;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [2:0]        lg_t;   // log2 of a byte count, 0 = illegal

  typedef struct packed {
    addr_t base;
    lg_t   lg;
  } txn_t;

  // element size in bytes -> log2 of segment size
  function automatic lg_t seg_lg(input logic [SIZE_W-1:0] bytes);
    case (bytes)
      5'd1:                 return 3'd5;
      5'd2:                 return 3'd6;
      5'd4, 5'd8, 5'd16:    return 3'd7;
      default:              return 3'd0;
    endcase
  endfunction

  function automatic addr_t seg_base(input addr_t a, input lg_t lg);
    addr_t keep;
    keep = '1 << lg;
    return a & keep;
  endfunction

  function automatic logic [1:0] quarter_of(input addr_t a, input lg_t lg);
    addr_t sh;
    sh = a >> (lg - 3'd2);
    return sh[1:0];
  endfunction

  function automatic logic [7:0] lg_bytes(input lg_t lg);
    return 8'd1 << lg;
  endfunction

  // two-step narrowing from quarter usage
  function automatic txn_t narrow(input addr_t base, input lg_t lg, input logic [3:0] q);
    txn_t r;
    logic lo, hi;
    r.base = base;
    r.lg   = lg;
    lo = q[0] | q[1];
    hi = q[2] | q[3];
    if (lg == 3'd7 && (lo ^ hi)) begin
      r.lg = 3'd6;
      if (hi) r.base = r.base + addr_t'(64);
      lo = q[0] | q[2];
      hi = q[1] | q[3];
    end
    if (r.lg == 3'd6 && (lo ^ hi)) begin
      r.lg = 3'd5;
      if (hi) r.base = r.base + addr_t'(32);
    end
    return r;
  endfunction
endpackage

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int LANES = 32,
  localparam int IW = $clog2(LANES)
) (
  input  logic [LANES-1:0] req,
  output logic [IW-1:0]    idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  localparam int IW   = $clog2(LANES),
  localparam int HALF = LANES / 2
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES-1:0]        pend,
  input  logic [IW-1:0]           lead,
  input  lg_t                     lg,
  input  logic                    atomic,
  output logic [LANES-1:0]        hit,
  output logic [3:0]              q_used,
  output addr_t                   base
);
  addr_t lead_addr;
  logic [3:0] q_hot [LANES];

  assign lead_addr = addr_flat[lead*ADDR_W +: ADDR_W];
  assign base      = seg_base(lead_addr, lg);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic UPPER = (i >= HALF);
    addr_t a;
    logic  same_half, same_seg, solo_ok;
    assign a         = addr_flat[i*ADDR_W +: ADDR_W];
    assign same_half = (UPPER == lead[IW-1]);
    assign same_seg  = (seg_base(a, lg) == base);
    assign solo_ok   = !atomic || (lead == IW'(i));
    assign hit[i]    = pend[i] && same_half && same_seg && solo_ok;
    assign q_hot[i]  = hit[i] ? (4'b0001 << quarter_of(a, lg)) : 4'b0000;
  end

  always_comb begin
    q_used = '0;
    for (int i = 0; i < LANES; i++) q_used = q_used | q_hot[i];
  end
endmodule

// File: rtl/coal_trim.sv
module coal_trim
  import coal_pkg::*;
(
  input  addr_t       seg,
  input  lg_t         lg,
  input  logic [3:0]  q_used,
  output addr_t       addr,
  output logic [7:0]  bytes
);
  txn_t t;
  assign t     = narrow(seg, lg, q_used);
  assign addr  = t.base;
  assign bytes = lg_bytes(t.lg);
endmodule

// File: rtl/seg_coalescer.sv
module seg_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0]       size_i,
  input  logic                    atomic_i,
  output logic                    tx_valid_o,
  input  logic                    tx_ready_i,
  output logic [ADDR_W-1:0]       tx_addr_o,
  output logic [7:0]              tx_size_o,
  output logic [LANES-1:0]        tx_lanes_o,
  output logic                    done_o,
  output logic                    size_err_o
);
  // captured request
  logic                    busy_q;
  logic                    atomic_q;
  logic                    bad_q;
  lg_t                     lg_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES*ADDR_W-1:0] addr_q;

  // named internal events
  logic [IW-1:0]    lead_idx;
  logic             lead_found;
  logic [LANES-1:0] match_lanes;
  logic [3:0]       q_used;
  addr_t            seg_addr;
  addr_t            trim_addr;
  logic [7:0]       trim_bytes;
  logic             accept;
  logic             fire;
  logic             finish;
  lg_t              start_lg;

  coal_lane_pick #(.LANES(LANES)) u_pick (
    .req   (pend_q),
    .idx   (lead_idx),
    .found (lead_found)
  );

  coal_seg_match #(.LANES(LANES)) u_match (
    .addr_flat (addr_q),
    .pend      (pend_q),
    .lead      (lead_idx),
    .lg        (lg_q),
    .atomic    (atomic_q),
    .hit       (match_lanes),
    .q_used    (q_used),
    .base      (seg_addr)
  );

  coal_trim u_trim (
    .seg    (seg_addr),
    .lg     (lg_q),
    .q_used (q_used),
    .addr   (trim_addr),
    .bytes  (trim_bytes)
  );

  assign start_lg   = seg_lg(size_i);
  assign accept     = start_i && !busy_q;
  assign tx_valid_o = busy_q && lead_found;
  assign fire       = tx_valid_o && tx_ready_i;
  assign finish     = busy_q && !lead_found;

  assign tx_addr_o  = tx_valid_o ? trim_addr   : '0;
  assign tx_size_o  = tx_valid_o ? trim_bytes  : '0;
  assign tx_lanes_o = tx_valid_o ? match_lanes : '0;
  assign done_o     = finish;
  assign size_err_o = finish && bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      atomic_q <= 1'b0;
      bad_q    <= 1'b0;
      lg_q     <= 3'd7;
      pend_q   <= '0;
      addr_q   <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      atomic_q <= atomic_i;
      bad_q    <= (start_lg == 3'd0);
      lg_q     <= (start_lg == 3'd0) ? 3'd7 : start_lg;
      pend_q   <= (start_lg == 3'd0) ? '0 : mask_i;
      addr_q   <= addr_i;
    end else if (finish) begin
      busy_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (fire) begin
      pend_q <= pend_q & ~match_lanes;
    end
  end
endmodule

// File: rtl/seg_coalescer_chk.sv
module seg_coalescer_chk #(
  parameter int LANES = 32,
  localparam int HALF = LANES / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             atomic,
  input logic [LANES-1:0] pend,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [31:0]      tx_addr,
  input logic [7:0]       tx_size,
  input logic [LANES-1:0] tx_lanes,
  input logic             done,
  input logic             size_err
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_size) && $stable(tx_lanes));

  a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_addr & (32'(tx_size) - 32'd1)) == 32'd0));

  a_r1_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_size == 8'd32 || tx_size == 8'd64 || tx_size == 8'd128));

  a_r2_one_half: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_lanes[HALF-1:0] == '0) || (tx_lanes[LANES-1:HALF] == '0));

  a_r7_lanes_pending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_lanes != '0) && ((tx_lanes & ~pend) == '0));

  a_r7_retired: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> ((pend & $past(tx_lanes)) == '0));

  a_r3_atomic_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && atomic |-> $countones(tx_lanes) == 1);

  a_r9_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid);

  a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> done);
endmodule

bind seg_coalescer seg_coalescer_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .atomic   (atomic_q),
  .pend     (pend_q),
  .tx_valid (tx_valid_o),
  .tx_ready (tx_ready_i),
  .tx_addr  (tx_addr_o),
  .tx_size  (tx_size_o),
  .tx_lanes (tx_lanes_o),
  .done     (done_o),
  .size_err (size_err_o)
);

// File: tb/tb_seg_coalescer.sv
module tb_seg_coalescer;
  localparam int LANES = 32;
  localparam int HALF  = LANES / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [LANES-1:0]  mask_i = '0;
  logic [LANES*32-1:0] addr_i = '0;
  logic [4:0]        size_i = 5'd4;
  logic              atomic_i = 1'b0;
  logic              tx_ready_i = 1'b1;
  logic              tx_valid_o;
  logic [31:0]       tx_addr_o;
  logic [7:0]        tx_size_o;
  logic [LANES-1:0]  tx_lanes_o;
  logic              done_o;
  logic              size_err_o;

  always #4 clk = ~clk;  // 125 MHz

  seg_coalescer #(.LANES(LANES)) dut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [31:0] ta [LANES];
  int          e_n;
  logic        e_err;
  logic [31:0] e_seg   [64];
  logic [31:0] e_addr  [64];
  logic [7:0]  e_size  [64];
  logic [31:0] e_lanes [64];
  logic [3:0]  e_q     [64];
  int          g_n;
  logic [31:0] g_addr  [64];
  logic [7:0]  g_size  [64];
  logic [31:0] g_lanes [64];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  // independent model built from the requirement text
  task automatic build_expect(input logic [31:0] mask, input logic [4:0] sz, input logic atom);
    int seg_bytes;
    e_n = 0;
    e_err = 1'b0;
    if (sz == 1) seg_bytes = 32;
    else if (sz == 2) seg_bytes = 64;
    else if (sz == 4 || sz == 8 || sz == 16) seg_bytes = 128;
    else begin
      e_err = 1'b1;
      return;
    end
    for (int h = 0; h < 2; h++) begin
      int first = e_n;
      for (int i = h * HALF; i < (h + 1) * HALF; i++) begin
        if (mask[i]) begin
          logic [31:0] sg;
          int qi, slot;
          sg = ta[i] - (ta[i] % seg_bytes);
          qi = (ta[i] / (seg_bytes / 4)) % 4;
          slot = -1;
          if (!atom)
            for (int j = first; j < e_n; j++) if (e_seg[j] == sg && slot < 0) slot = j;
          if (slot < 0) begin
            slot = e_n;
            e_seg[slot] = sg; e_q[slot] = 4'b0; e_lanes[slot] = 32'b0;
            e_n++;
          end
          e_q[slot][qi] = 1'b1;
          e_lanes[slot][i] = 1'b1;
        end
      end
    end
    for (int j = 0; j < e_n; j++) begin
      int b = seg_bytes;
      logic [31:0] a = e_seg[j];
      logic [3:0] q = e_q[j];
      bit lo = q[0] || q[1];
      bit hi = q[2] || q[3];
      if (b == 128 && lo != hi) begin
        b = 64;
        if (hi) a = a + 64;
        lo = q[0] || q[2];
        hi = q[1] || q[3];
      end
      if (b == 64 && lo != hi) begin
        b = 32;
        if (hi) a = a + 32;
      end
      e_addr[j] = a;
      e_size[j] = 8'(b);
    end
  endtask

  // mode 0: always ready, 1: gapped ready, 2: spurious start while busy
  task automatic run_case(input string tag, input logic [31:0] mask, input logic [4:0] sz,
                          input logic atom, input int mode);
    int cyc = 0, done_cyc = -1, last_fire = -1;
    bit p_stall = 0;
    logic [31:0] p_addr = 0, p_lanes = 0;
    logic [7:0] p_size = 0;
    bit err_seen = 0;
    build_expect(mask, sz, atom);
    g_n = 0;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) addr_i[i*32 +: 32] = ta[i];
    mask_i = mask; size_i = sz; atomic_i = atom; start_i = 1'b1;
    while (done_cyc < 0 && cyc < 2000) begin
      @(negedge clk);
      start_i = 1'b0;
      if (mode == 2 && cyc == 1) begin
        start_i = 1'b1; mask_i = ~mask; atomic_i = ~atom;
      end
      tx_ready_i = (mode == 1) ? ((cyc % 3) == 2) : 1'b1;
      #1;
      if (p_stall) begin
        chk(tx_valid_o && tx_addr_o == p_addr && tx_size_o == p_size && tx_lanes_o == p_lanes,
            "R9", "held output changed while stalled", tx_addr_o, p_addr);
      end
      p_stall = tx_valid_o && !tx_ready_i;
      p_addr = tx_addr_o; p_size = tx_size_o; p_lanes = tx_lanes_o;
      if (tx_valid_o && tx_ready_i) begin
        if (g_n < 64) begin
          g_addr[g_n] = tx_addr_o; g_size[g_n] = tx_size_o; g_lanes[g_n] = tx_lanes_o;
        end
        g_n++;
        last_fire = cyc;
      end
      if (done_o) begin
        done_cyc = cyc;
        err_seen = size_err_o;
      end
      cyc++;
    end
    chk(done_cyc >= 0, tag, "done never seen", 0, 1);
    chk(g_n == e_n, tag, "transaction count", g_n, e_n);
    for (int j = 0; j < e_n && j < g_n; j++) begin
      chk(g_addr[j] == e_addr[j], tag, $sformatf("tx %0d address", j), g_addr[j], e_addr[j]);
      chk(g_size[j] == e_size[j], tag, $sformatf("tx %0d size", j), 32'(g_size[j]), 32'(e_size[j]));
      chk(g_lanes[j] == e_lanes[j], tag, $sformatf("tx %0d lanes", j), g_lanes[j], e_lanes[j]);
    end
    chk(err_seen == e_err, "R10", $sformatf("%s size_err at done", tag), 32'(err_seen), 32'(e_err));
    if (e_n == 0)
      chk(done_cyc == 0, "R7", $sformatf("%s done latency without work", tag), done_cyc, 0);
    else
      chk(done_cyc == last_fire + 1, "R9", $sformatf("%s done after last handshake", tag),
          done_cyc, last_fire + 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      chk(!done_o && !tx_valid_o, "R9", $sformatf("%s quiet after done (R11)", tag),
          {30'b0, done_o, tx_valid_o}, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) ta[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid_o && !done_o && !size_err_o, "R9", "reset outputs idle",
        {29'b0, tx_valid_o, done_o, size_err_o}, 0);
    rst_n = 1'b1;

    // R4 R5: 4-byte unit stride, halves narrow to 64-byte low / high
    for (int i = 0; i < LANES; i++) ta[i] = 32'h1000 + 4 * i;
    run_case("R4", 32'hFFFF_FFFF, 5'd4, 1'b0, 0);

    // R2: 1-byte stride, both halves in one 32-byte segment, kept apart
    for (int i = 0; i < LANES; i++) ta[i] = 32'h2000 + i;
    run_case("R2", 32'hFFFF_FFFF, 5'd1, 1'b0, 0);

    // R6: 2-byte elements, 64-byte segment narrowing to 32
    for (int i = 0; i < LANES; i++) ta[i] = 32'h3000 + 2 * i;
    run_case("R6", 32'hFFFF_FFFF, 5'd2, 1'b0, 0);

    // R5: single lane in quarter 3 -> 32 bytes at +96
    for (int i = 0; i < LANES; i++) ta[i] = 32'h4064;
    run_case("R5", 32'h0000_0020, 5'd8, 1'b0, 0);

    // R3: atomic, all lanes same address
    for (int i = 0; i < LANES; i++) ta[i] = 32'h5000;
    run_case("R3", 32'hFFFF_FFFF, 5'd4, 1'b1, 0);

    // R8 R7: descending addresses, sparse mask, inactive lanes scattered
    for (int i = 0; i < LANES; i++) ta[i] = 32'h9000 + (31 - i) * 32'h50;
    run_case("R8", 32'h8C21_5A0F, 5'd4, 1'b0, 0);

    // R7: no active lanes
    run_case("R7", 32'h0, 5'd4, 1'b0, 0);

    // R10: illegal element size
    for (int i = 0; i < LANES; i++) ta[i] = 32'h6000 + 4 * i;
    run_case("R10", 32'hFFFF_FFFF, 5'd3, 1'b0, 0);

    // R9: gapped ready, every lane its own 128-byte segment
    for (int i = 0; i < LANES; i++) ta[i] = 32'h7000 + 128 * i + 4;
    run_case("R9", 32'hFFFF_FFFF, 5'd4, 1'b0, 1);

    // R1: 16-byte elements, two full 128-byte segments per half
    for (int i = 0; i < LANES; i++) ta[i] = 32'h8000 + 16 * i;
    run_case("R1", 32'hFFFF_FFFF, 5'd16, 1'b0, 0);

    // R11: start pulsed while busy is ignored
    for (int i = 0; i < LANES; i++) ta[i] = 32'hA000 + 8 * i;
    run_case("R11", 32'h00FF_F0F0, 5'd8, 1'b0, 2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule